// File: doc/BRIEF.md
# Display Link Packet Header Builder

This block assembles one display-link packet per request. The requester supplies a data type, a virtual channel, two header data bytes and a packet kind. The block builds the 32-bit header and protects its low 24 bits with a 6-bit ECC. It then emits the packet as a byte stream under valid/ready flow control.

There are four packet kinds:
- **Short packets** consist of the header alone.
- **Long packets** treat the two data bytes as a 16-bit word count. The block forwards that many payload bytes from a second valid/ready byte input, then appends a 16-bit CRC footer.
- **Blanking packets** also use the word count, but the block generates the payload itself by repeating a fill byte. The footer is the CRC of that generated payload.

From the cycle after a request is accepted, the block also reports the length of the packet being sent. Splitting the stream across lanes and serialising it are done by the next stage.

Top module: `pkt_hdr_builder`

## Requirements
- R1: The header goes out least significant byte first: byte 0 = {vc, dt} (data type in bits 5:0, channel in bits 7:6), byte 1 = data byte 0, byte 2 = data byte 1, byte 3 = ECC. For long and blanking packets the word count is {data byte 1, data byte 0}.
- R2: ECC bit k is the XOR of the 24 header bits h[23:0] selected by mask k: 0xF12CB7, 0xF2555B, 0x749A6D, 0xB8E38E, 0xDF03F0, 0xEFFC00 for k = 0 to 5.
- R3: Bits 7:6 of the ECC byte are always zero.
- R4: Kind encoding: 0 = short with two parameters, 1 = short with one parameter, 2 = long, 3 = blanking. For kind 1, header byte 2 and the ECC treat data byte 1 as zero, whatever value is applied.
- R5: A long packet forwards exactly word-count bytes from the payload input, in arrival order, then sends the CRC footer low byte first. A packet of kind 0 or 1 ends after header byte 3 and takes no payload bytes.
- R6: The footer CRC uses polynomial x^16+x^12+x^5+1. It is processed LSB first per byte (reflected constant 0x8408), seeded with 0xFFFF, and has no final inversion. For the bytes "123456789" it is 0x6F91.
- R7: A blanking packet sends the fill byte word-count times, consumes nothing from the payload input, and its footer is the CRC of that filled payload.
- R8: From the cycle after acceptance until the next acceptance, out_len equals 3 for short packets and word count + 5 for long and blanking packets.
- R9: A long or blanking packet with word count zero sends its header followed immediately by footer bytes 0xFF, 0xFF.
- R10: req_ready is high only while no packet is in progress. While out_valid is high and out_ready is low, out_data and out_valid hold. The exception is a long packet's payload, which follows the payload input. out_last marks only the final byte of a packet.
- R11: After reset, req_ready is 1, out_valid is 0 and out_len is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Packet request present |
| req_ready | output | 1 | Request accepted when both are high |
| req_kind | input | 2 | Packet kind (R4) |
| req_dt | input | 6 | Data type |
| req_vc | input | 2 | Virtual channel |
| req_b0 | input | 8 | Data byte 0 / word count low byte |
| req_b1 | input | 8 | Data byte 1 / word count high byte |
| req_fill | input | 8 | Fill byte for blanking packets |
| pl_valid | input | 1 | Payload byte present |
| pl_ready | output | 1 | Payload byte taken when both are high |
| pl_data | input | 8 | Payload byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the packet |
| out_len | output | WC_W+1 | Packet byte count minus one |

## Verification
The situation hardest to reach is back-pressure that falls exactly on a boundary between phases: the ECC byte, the first payload byte, or the switch from the last payload byte to the footer. It is most delicate when the payload source stalls at the same time. The stimulus drives out_ready and pl_valid independently at random on every cycle across many packets with random kinds and word counts, so these coincidences happen often. Directed packets cover word count zero, word count one, the one-parameter short form with a non-zero second byte, and the known CRC check string.

// File: rtl/pkt_pkg.sv
package pkt_pkg;

  typedef enum logic [1:0] {
    K_SHORT2 = 2'd0,
    K_SHORT1 = 2'd1,
    K_LONG   = 2'd2,
    K_BLANK  = 2'd3
  } kind_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_HDR  = 2'd1,
    S_PAY  = 2'd2,
    S_FTR  = 2'd3
  } st_t;

  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'h8408;

  // Parity selection for each header ECC bit
  function automatic logic [23:0] ecc_mask(input int k);
    case (k)
      0:       ecc_mask = 24'hF12CB7;
      1:       ecc_mask = 24'hF2555B;
      2:       ecc_mask = 24'h749A6D;
      3:       ecc_mask = 24'hB8E38E;
      4:       ecc_mask = 24'hDF03F0;
      default: ecc_mask = 24'hEFFC00;
    endcase
  endfunction

  // One byte of reflected CRC, bit 0 first
  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/hdr_ecc.sv
module hdr_ecc
  import pkt_pkg::*;
(
  input  logic [5:0]  dt,
  input  logic [1:0]  vc,
  input  logic [7:0]  b0,
  input  logic [7:0]  b1,
  output logic [31:0] hdr
);
  localparam int ECC_BITS = 6;

  logic [23:0]         body;
  logic [ECC_BITS-1:0] ecc;

  assign body = {b1, b0, vc, dt};

  for (genvar g = 0; g < ECC_BITS; g++) begin : g_par
    assign ecc[g] = ^(body & ecc_mask(g));
  end

  assign hdr = {2'b00, ecc, body};
endmodule

// File: rtl/crc_acc.sv
module crc_acc
  import pkt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n)    crc <= CRC_SEED;
    else if (init) crc <= CRC_SEED;
    else if (en)   crc <= crc_byte(crc, din);
  end

  assert_crc_seed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> crc == 16'hFFFF);
endmodule

// File: rtl/pkt_seq.sv
module pkt_seq
  import pkt_pkg::*;
#(
  parameter int WC_W  = 16,
  parameter int LEN_W = WC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [31:0]      req_hdr,
  input  logic [WC_W-1:0]  req_wc,
  input  logic [7:0]       req_fill,
  input  logic             pl_valid,
  output logic             pl_ready,
  input  logic [7:0]       pl_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic [LEN_W-1:0] out_len,
  output logic             crc_init,
  output logic             crc_en,
  output logic [7:0]       crc_din,
  input  logic [15:0]      crc_val
);
  localparam logic [LEN_W-1:0] SHORT_LEN = LEN_W'(3);
  localparam logic [LEN_W-1:0] LONG_ADD  = LEN_W'(5);

  st_t             st;
  kind_t           kind_q;
  logic [31:0]     hdr_q;
  logic [WC_W-1:0] wc_q;
  logic [WC_W-1:0] cnt;
  logic [7:0]      fill_q;
  logic [1:0]      idx;

  logic accept, fire, has_pay, from_src, hold_ok, pay_end;
  kind_t req_k;

  assign req_k     = kind_t'(req_kind);
  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign has_pay   = (kind_q == K_LONG) || (kind_q == K_BLANK);
  assign from_src  = (kind_q == K_LONG);
  assign fire      = out_valid && out_ready;
  assign pay_end   = (cnt == wc_q - 1'b1);
  assign hold_ok   = !(st == S_PAY && from_src);

  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'h00;
    case (st)
      S_HDR: begin
        out_valid = 1'b1;
        out_data  = hdr_q[{idx, 3'b000} +: 8];
      end
      S_PAY: begin
        out_valid = from_src ? pl_valid : 1'b1;
        out_data  = from_src ? pl_data : fill_q;
      end
      S_FTR: begin
        out_valid = 1'b1;
        out_data  = idx[0] ? crc_val[15:8] : crc_val[7:0];
      end
      default: ;
    endcase
  end

  assign out_last = (st == S_HDR && idx == 2'd3 && !has_pay) ||
                    (st == S_FTR && idx == 2'd1);
  assign pl_ready = (st == S_PAY) && from_src && out_ready;
  assign crc_init = accept;
  assign crc_en   = (st == S_PAY) && fire;
  assign crc_din  = out_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind_q  <= K_SHORT2;
      hdr_q   <= '0;
      wc_q    <= '0;
      cnt     <= '0;
      fill_q  <= '0;
      idx     <= '0;
      out_len <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st     <= S_HDR;
          idx    <= '0;
          kind_q <= req_k;
          hdr_q  <= req_hdr;
          wc_q   <= req_wc;
          fill_q <= req_fill;
          if (req_k == K_LONG || req_k == K_BLANK)
            out_len <= LEN_W'(req_wc) + LONG_ADD;
          else
            out_len <= SHORT_LEN;
        end
        S_HDR: if (fire) begin
          if (idx == 2'd3) begin
            idx <= '0;
            cnt <= '0;
            if (!has_pay)        st <= S_IDLE;
            else if (wc_q == '0) st <= S_FTR;
            else                 st <= S_PAY;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        S_PAY: if (fire) begin
          if (pay_end) begin
            st  <= S_FTR;
            idx <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_FTR: if (fire) begin
          if (idx == 2'd1) st <= S_IDLE;
          idx <= idx + 2'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_ecc_top_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HDR && idx == 2'd3) |-> out_data[7:6] == 2'b00);

  assert_short1_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HDR && idx == 2'd2 && kind_q == K_SHORT1) |-> out_data == 8'h00);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && hold_ok) |=> (out_valid && $stable(out_data)));

  assert_pl_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && pl_ready) |-> fire);

  assert_short_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_k == K_SHORT1 || req_k == K_SHORT2)) |=> out_len == SHORT_LEN);

  assert_zero_wc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HDR && idx == 2'd3 && fire && has_pay && wc_q == '0)
      |=> (st == S_FTR && out_data == 8'hFF));

  assert_done_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_last) |=> req_ready);
endmodule

// File: rtl/pkt_hdr_builder.sv
module pkt_hdr_builder
  import pkt_pkg::*;
#(
  parameter int WC_W  = 16,
  parameter int LEN_W = WC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [5:0]       req_dt,
  input  logic [1:0]       req_vc,
  input  logic [7:0]       req_b0,
  input  logic [7:0]       req_b1,
  input  logic [7:0]       req_fill,
  input  logic             pl_valid,
  output logic             pl_ready,
  input  logic [7:0]       pl_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic [LEN_W-1:0] out_len
);
  logic [7:0]      b1_eff;
  logic [31:0]     hdr;
  logic [WC_W-1:0] wc;
  logic            crc_init, crc_en;
  logic [7:0]      crc_din;
  logic [15:0]     crc_val;

  assign b1_eff = (kind_t'(req_kind) == K_SHORT1) ? 8'h00 : req_b1;
  assign wc     = WC_W'({req_b1, req_b0});

  hdr_ecc u_ecc (
    .dt (req_dt), .vc (req_vc), .b0 (req_b0), .b1 (b1_eff), .hdr (hdr)
  );

  crc_acc u_crc (
    .clk (clk), .rst_n (rst_n), .init (crc_init), .en (crc_en),
    .din (crc_din), .crc (crc_val)
  );

  pkt_seq #(.WC_W (WC_W), .LEN_W (LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .req_hdr   (hdr),
    .req_wc    (wc),
    .req_fill  (req_fill),
    .pl_valid  (pl_valid),
    .pl_ready  (pl_ready),
    .pl_data   (pl_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_len   (out_len),
    .crc_init  (crc_init),
    .crc_en    (crc_en),
    .crc_din   (crc_din),
    .crc_val   (crc_val)
  );
endmodule

// File: tb/sim_pkt_hdr_builder.sv
`timescale 1ns/1ps
module sim_pkt_hdr_builder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_ready;
  logic [1:0]  req_kind = 0, req_vc = 0;
  logic [5:0]  req_dt = 0;
  logic [7:0]  req_b0 = 0, req_b1 = 0, req_fill = 0;
  logic        pl_valid = 0, pl_ready;
  logic [7:0]  pl_data = 0;
  logic        out_valid, out_ready = 0, out_last;
  logic [7:0]  out_data;
  logic [16:0] out_len;

  pkt_hdr_builder u0 (.*);

  int checks = 0, failures = 0;
  bit bp_en = 0;
  bit pl_pend = 0;
  logic [7:0] pl_q[$];
  logic [7:0] got_q[$];
  bit         got_last[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [5:0] b_ecc(input logic [23:0] h);
    logic [5:0] e;
    e[0] = h[0]^h[1]^h[2]^h[4]^h[5]^h[7]^h[10]^h[11]^h[13]^h[16]^h[20]^h[21]^h[22]^h[23];
    e[1] = h[0]^h[1]^h[3]^h[4]^h[6]^h[8]^h[10]^h[12]^h[14]^h[17]^h[20]^h[21]^h[22]^h[23];
    e[2] = h[0]^h[2]^h[3]^h[5]^h[6]^h[9]^h[11]^h[12]^h[15]^h[18]^h[20]^h[21]^h[22];
    e[3] = h[1]^h[2]^h[3]^h[7]^h[8]^h[9]^h[13]^h[14]^h[15]^h[19]^h[20]^h[21]^h[23];
    e[4] = (^h[9:4]) ^ (^h[20:16]) ^ h[22] ^ h[23];
    e[5] = (^h[19:10]) ^ h[21] ^ h[22] ^ h[23];
    return e;
  endfunction

  // Bit-serial CRC written as a shift register with taps on bits 15, 10, 3
  function automatic logic [15:0] b_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = {fb, r[15:1]};
      r[10] = r[10] ^ fb;
      r[3]  = r[3] ^ fb;
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (pl_pend) void'(pl_q.pop_front());
      out_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
      pl_valid  = (pl_q.size() > 0) && (bp_en ? (($urandom % 3) != 0) : 1'b1);
      pl_data   = (pl_q.size() > 0) ? pl_q[0] : 8'h00;
      #1;
      pl_pend = pl_valid && pl_ready;
      if (out_valid && out_ready) begin
        got_q.push_back(out_data);
        got_last.push_back(out_last);
      end
    end
  end

  // kind: 0 short2, 1 short1, 2 long, 3 blank; pay used for long packets
  task automatic run_pkt(input logic [1:0] kind, input logic [5:0] dt, input logic [1:0] vc,
                         input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] fill,
                         input logic [7:0] pay[$], input string tag);
    logic [7:0] exp[$];
    logic [7:0] b1e;
    logic [15:0] crc;
    int wc, wait_n;
    logic [16:0] exp_len;
    b1e = (kind == 2'd1) ? 8'h00 : b1;
    wc  = {b1, b0};
    exp.push_back({vc, dt});
    exp.push_back(b0);
    exp.push_back(b1e);
    exp.push_back({2'b00, b_ecc({b1e, b0, vc, dt})});
    exp_len = 17'd3;
    if (kind >= 2'd2) begin
      crc = 16'hFFFF;
      for (int i = 0; i < wc; i++) begin
        logic [7:0] v;
        v = (kind == 2'd2) ? pay[i] : fill;
        exp.push_back(v);
        crc = b_crc(crc, v);
      end
      exp.push_back(crc[7:0]);
      exp.push_back(crc[15:8]);
      exp_len = 17'(wc + 5);
      if (kind == 2'd2) foreach (pay[i]) pl_q.push_back(pay[i]);
    end
    got_q.delete();
    got_last.delete();
    @(negedge clk);
    req_kind = kind; req_dt = dt; req_vc = vc; req_b0 = b0; req_b1 = b1; req_fill = fill;
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_b1 = ~req_b1;
    chk(out_len == exp_len, {tag, " R8 len"}, out_len, exp_len);
    chk(req_ready == 1'b0, {tag, " R10 busy"}, req_ready, 0);
    wait_n = 0;
    while (got_q.size() < exp.size() && wait_n < 4000) begin @(negedge clk); wait_n++; end
    repeat (3) @(negedge clk);
    chk(got_q.size() == exp.size(), {tag, " R5 count"}, got_q.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got_q.size(); i++) begin
      chk(got_q[i] == exp[i], $sformatf("%s byte%0d R1 R2 R5 R7", tag, i), got_q[i], exp[i]);
      chk(got_last[i] == (i == exp.size() - 1), $sformatf("%s last%0d R10", tag, i),
          got_last[i], (i == exp.size() - 1));
    end
    chk(pl_q.size() == 0, {tag, " R5 R7 payload use"}, pl_q.size(), 0);
    chk(req_ready == 1'b1, {tag, " R10 idle"}, req_ready, 1);
    chk(out_len == exp_len, {tag, " R8 held"}, out_len, exp_len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] none[$];
    logic [7:0] p[$];
    logic [7:0] digits[$];
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready", req_ready, 1);
    chk(out_valid == 1'b0, "R11 valid", out_valid, 0);
    chk(out_len == 17'd0, "R11 len", out_len, 0);
    rst_n = 1'b1;

    run_pkt(2'd0, 6'h15, 2'd1, 8'h11, 8'h2C, 8'h00, none, "short2 R1");
    run_pkt(2'd1, 6'h05, 2'd2, 8'h29, 8'hA7, 8'h00, none, "short1 R4");
    run_pkt(2'd2, 6'h39, 2'd0, 8'h00, 8'h00, 8'h00, none, "long wc0 R9");
    run_pkt(2'd3, 6'h19, 2'd3, 8'h00, 8'h00, 8'h5A, none, "blank wc0 R9");
    p = '{8'hC3};
    run_pkt(2'd2, 6'h39, 2'd1, 8'h01, 8'h00, 8'h00, p, "long wc1 R5");
    run_pkt(2'd3, 6'h19, 2'd0, 8'h07, 8'h00, 8'h00, none, "blank fill0 R7");
    digits = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    run_pkt(2'd2, 6'h29, 2'd0, 8'h09, 8'h00, 8'h00, digits, "check string R6");
    chk(got_q.size() == 15 && got_q[13] == 8'h91 && got_q[14] == 8'h6F, "R6 known CRC",
        got_q.size() == 15 ? {got_q[14], got_q[13]} : 16'h0, 16'h6F91);

    bp_en = 1;
    for (int n = 0; n < 60; n++) begin
      logic [1:0] k;
      logic [7:0] b0, b1;
      k = 2'($urandom);
      b0 = 8'($urandom);
      b1 = 8'($urandom);
      if (k >= 2'd2) begin b0 = 8'($urandom % 24); b1 = 8'h00; end
      p.delete();
      if (k == 2'd2) for (int i = 0; i < b0; i++) p.push_back(8'($urandom));
      run_pkt(k, 6'($urandom), 2'($urandom), b0, b1, 8'($urandom), p,
              $sformatf("rand%0d R2 R10", n));
    end
    finish_run();
  end
endmodule